// File: doc/BRIEF.md
# Folded Cyclic-Prefix Symbol Synchronizer

This block locates where an OFDM symbol begins within a stream of received complex samples. Each symbol has a 32-sample FFT body and an 8-sample cyclic prefix, so one symbol spans 40 samples. The prefix repeats the last eight body samples. For that reason, a sample multiplied by the conjugate of the sample 32 positions later gives a large, phase-aligned product across the prefix. The block sums these products over a sliding window eight products long. It uses one complex multiplier, a 32-deep sample delay line and an 8-deep product delay line.

A single correlation window is noisy when the FFT is this short. The block therefore adds the window metric for each position within the symbol across FOLD consecutive symbol periods. It keeps the running sums in a 40-entry fold memory, reading each entry, adding to it and writing it back. During the last period it tracks the position whose folded sum has the largest |Re|+|Im|. When acquisition ends it raises a one-cycle done pulse and presents the position of the winner, modulo 40. The block is used only during acquisition. Samples that arrive after the result are not examined until the next start.

Top module: `cp_fold_sync`

## Requirements
- R1: After reset, `symDone` is 0 and `symStart` is 0.
- R2: A `start` pulse begins a new acquisition and discards all history from earlier or unfinished runs. A sample presented in the same cycle as `start` is not used. The first accepted sample after `start` has index t = 0.
- R3: A cycle with `sampValid` low advances nothing. Idle cycles inserted between accepted samples do not change the result.
- R4: The window metric for position m is g(m) = sum over i = 0..7 of y(m+i)·conj(y(m+i+32)). Here y(t) is the accepted sample with index t, written as a signed real part plus a signed imaginary part.
- R5: For p = 0..39, the folded metric is F(p) = sum over k = 0..FOLD-1 of g(p+40k). It needs accepted samples t = 0 .. 40·FOLD+38. No 1/FOLD scaling is applied.
- R6: `symStart` is the p that maximizes |Re F(p)|+|Im F(p)|. On a tie, the smallest p wins, so an all-equal metric gives 0.
- R7: `symDone` is high for exactly one cycle, in the cycle right after the clock edge that accepts sample index 40·FOLD+38. It is low at all other times.
- R8: From the `symDone` pulse until the next `symDone`, `symStart` holds its value. Samples that arrive after `symDone` and before the next `start` are ignored.
- R9: `symStart` always lies in 0..39.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins an acquisition |
| sampValid | input | 1 | Qualifies the sample on sampRe/sampIm |
| sampRe | input | SAMP_W (8) | Signed real part of the received sample |
| sampIm | input | SAMP_W (8) | Signed imaginary part of the received sample |
| symStart | output | 6 | Detected symbol start position, modulo 40 |
| symDone | output | 1 | One-cycle pulse when symStart holds a new result |

## Verification
The embedded properties are checked on every cycle:
- the done pulse lasts a single cycle and only ever follows an accepted sample;
- the fold position and the reported start stay below the symbol length;
- the result never changes outside the final metric step;
- a start always leaves the window sum at zero.

Whether the reported position is the correct argmax of the folded metric can be shown only by the bench's scenarios. The bench recomputes the metric arithmetically from the requirement formulas. It sweeps prefix-structured streams over all 40 offsets, runs zero, constant and full-scale streams, inserts idle bubbles, and restarts in the middle of a run.

// File: rtl/cpsync_pkg.sv
package cpsync_pkg;
  // Strobes issued by the control unit to the datapath each cycle
  typedef struct packed {
    logic clearLine;   // start: flush delay lines and window sum
    logic shift;       // an accepted sample enters the delay lines
    logic metricStep;  // the window sum now covers a full metric position
    logic accFirst;    // first fold period: overwrite instead of accumulate
    logic peakEn;      // last fold period: folded value is final, compare it
    logic lastStep;    // final metric position of the acquisition
  } syncStrobes_t;
endpackage

// File: rtl/cpsync_ctrl.sv
module cpsync_ctrl
  import cpsync_pkg::*;
#(
  parameter int NS    = 40,
  parameter int FOLD  = 4,
  parameter int POS_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               sampValid,
  output syncStrobes_t       strb,
  output logic [POS_W-1:0]   pos,
  output logic               doneOut
);
  localparam int FOLD_W = $clog2(FOLD + 1);

  logic              running;
  logic [POS_W-1:0]  fillCnt;
  logic [FOLD_W-1:0] fold;
  logic              step, metricStep, lastStep;

  always_comb begin
    step       = running && sampValid && !start;
    metricStep = step && (fillCnt == POS_W'(NS - 1));
    lastStep   = metricStep && (pos == POS_W'(NS - 1)) && (fold == FOLD_W'(FOLD - 1));
    strb.clearLine  = start;
    strb.shift      = step;
    strb.metricStep = metricStep;
    strb.accFirst   = (fold == '0);
    strb.peakEn     = (fold == FOLD_W'(FOLD - 1));
    strb.lastStep   = lastStep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      fillCnt <= '0;
      pos     <= '0;
      fold    <= '0;
      doneOut <= 1'b0;
    end else begin
      doneOut <= lastStep;
      if (start) begin
        running <= 1'b1;
        fillCnt <= '0;
        pos     <= '0;
        fold    <= '0;
      end else if (step) begin
        if (!metricStep) fillCnt <= fillCnt + 1'b1;
        else if (pos == POS_W'(NS - 1)) begin
          pos <= '0;
          if (lastStep) running <= 1'b0;
          else fold <= fold + 1'b1;
        end else pos <= pos + 1'b1;
      end
    end
  end

  // R7
  // done_pulse_chk: the done pulse never lasts two cycles
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneOut |=> !doneOut);

  // R7
  // done_after_valid_chk: done follows the edge that accepted a sample
  done_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneOut |-> $past(sampValid));

  // R9
  // pos_range_chk: fold position stays inside one symbol
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos < POS_W'(NS));
endmodule

// File: rtl/cpsync_datapath.sv
module cpsync_datapath
  import cpsync_pkg::*;
#(
  parameter int SAMP_W  = 8,
  parameter int FFT_LEN = 32,
  parameter int CP_LEN  = 8,
  parameter int NS      = 40,
  parameter int FOLD    = 4,
  parameter int POS_W   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  syncStrobes_t             strb,
  input  logic [POS_W-1:0]         pos,
  input  logic signed [SAMP_W-1:0] sampRe,
  input  logic signed [SAMP_W-1:0] sampIm,
  output logic [POS_W-1:0]         resultPos
);
  localparam int PROD_W = 2 * SAMP_W + 1;
  localparam int WIN_W  = PROD_W + $clog2(CP_LEN);
  localparam int ACC_W  = WIN_W + $clog2(FOLD + 1);
  localparam int MAG_W  = ACC_W + 1;

  logic signed [SAMP_W-1:0] lineRe [FFT_LEN];
  logic signed [SAMP_W-1:0] lineIm [FFT_LEN];
  logic signed [PROD_W-1:0] prodLineRe [CP_LEN];
  logic signed [PROD_W-1:0] prodLineIm [CP_LEN];
  logic signed [WIN_W-1:0]  winSumRe, winSumIm, winNextRe, winNextIm;
  logic signed [ACC_W-1:0]  accRe [NS];
  logic signed [ACC_W-1:0]  accIm [NS];
  logic signed [ACC_W-1:0]  sumRe, sumIm, baseRe, baseIm;
  logic signed [PROD_W-1:0] prodRe, prodIm;
  logic [MAG_W-1:0]         magNew, bestMag;
  logic [POS_W-1:0]         bestPos;
  logic                     peakLoad;

  function automatic logic [MAG_W-1:0] absVal(input logic signed [ACC_W-1:0] v);
    logic signed [MAG_W-1:0] w;
    w = v;
    return (w < 0) ? MAG_W'(-w) : MAG_W'(w);
  endfunction

  always_comb begin
    logic signed [PROD_W-1:0] oRe, oIm, nRe, nIm;
    logic signed [WIN_W-1:0]  pRe, pIm, xRe, xIm;
    logic signed [ACC_W-1:0]  wRe, wIm;
    oRe = lineRe[FFT_LEN-1];
    oIm = lineIm[FFT_LEN-1];
    nRe = sampRe;
    nIm = sampIm;
    // older sample times conjugate of the newest one
    prodRe = oRe * nRe + oIm * nIm;
    prodIm = oIm * nRe - oRe * nIm;
    pRe = prodRe;
    pIm = prodIm;
    xRe = prodLineRe[CP_LEN-1];
    xIm = prodLineIm[CP_LEN-1];
    winNextRe = winSumRe + pRe - xRe;
    winNextIm = winSumIm + pIm - xIm;
    baseRe = strb.accFirst ? '0 : accRe[pos];
    baseIm = strb.accFirst ? '0 : accIm[pos];
    wRe = winNextRe;
    wIm = winNextIm;
    sumRe  = baseRe + wRe;
    sumIm  = baseIm + wIm;
    magNew = absVal(sumRe) + absVal(sumIm);
    peakLoad = strb.metricStep && strb.peakEn && ((pos == '0) || (magNew > bestMag));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < FFT_LEN; i++) begin lineRe[i] <= '0; lineIm[i] <= '0; end
      for (int i = 0; i < CP_LEN; i++) begin prodLineRe[i] <= '0; prodLineIm[i] <= '0; end
      winSumRe <= '0;
      winSumIm <= '0;
    end else if (strb.clearLine) begin
      for (int i = 0; i < FFT_LEN; i++) begin lineRe[i] <= '0; lineIm[i] <= '0; end
      for (int i = 0; i < CP_LEN; i++) begin prodLineRe[i] <= '0; prodLineIm[i] <= '0; end
      winSumRe <= '0;
      winSumIm <= '0;
    end else if (strb.shift) begin
      lineRe[0] <= sampRe;
      lineIm[0] <= sampIm;
      for (int i = 1; i < FFT_LEN; i++) begin lineRe[i] <= lineRe[i-1]; lineIm[i] <= lineIm[i-1]; end
      prodLineRe[0] <= prodRe;
      prodLineIm[0] <= prodIm;
      for (int i = 1; i < CP_LEN; i++) begin
        prodLineRe[i] <= prodLineRe[i-1];
        prodLineIm[i] <= prodLineIm[i-1];
      end
      winSumRe <= winNextRe;
      winSumIm <= winNextIm;
    end
  end

  // fold memory: read-modify-write of one position per metric step
  always_ff @(posedge clk) begin
    if (strb.metricStep) begin
      accRe[pos] <= sumRe;
      accIm[pos] <= sumIm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bestMag   <= '0;
      bestPos   <= '0;
      resultPos <= '0;
    end else begin
      if (peakLoad) begin
        bestMag <= magNew;
        bestPos <= pos;
      end
      if (strb.lastStep) resultPos <= peakLoad ? pos : bestPos;
    end
  end

  // R9
  // result_range_chk: reported start lies inside one symbol
  result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resultPos < POS_W'(NS));

  // R8
  // result_hold_chk: result only moves on the final metric step
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.lastStep |=> $stable(resultPos));

  // R2
  // win_clear_chk: a start leaves the window sum empty
  win_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clearLine |=> (winSumRe == '0 && winSumIm == '0));
endmodule

// File: rtl/cp_fold_sync.sv
module cp_fold_sync
  import cpsync_pkg::*;
#(
  parameter int SAMP_W  = 8,
  parameter int FFT_LEN = 32,
  parameter int CP_LEN  = 8,
  parameter int FOLD    = 4,
  localparam int NS     = FFT_LEN + CP_LEN,
  localparam int POS_W  = $clog2(NS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     sampValid,
  input  logic signed [SAMP_W-1:0] sampRe,
  input  logic signed [SAMP_W-1:0] sampIm,
  output logic [POS_W-1:0]         symStart,
  output logic                     symDone
);
  syncStrobes_t      strb;
  logic [POS_W-1:0]  pos;

  cpsync_ctrl #(.NS(NS), .FOLD(FOLD), .POS_W(POS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .sampValid(sampValid),
    .strb(strb), .pos(pos), .doneOut(symDone)
  );

  cpsync_datapath #(
    .SAMP_W(SAMP_W), .FFT_LEN(FFT_LEN), .CP_LEN(CP_LEN),
    .NS(NS), .FOLD(FOLD), .POS_W(POS_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .pos(pos),
    .sampRe(sampRe), .sampIm(sampIm), .resultPos(symStart)
  );
endmodule

// File: tb/test_cp_fold_sync.sv
module test_cp_fold_sync;
  localparam int FOLD  = 4;
  localparam int NS    = 40;
  localparam int NFFT  = 32;
  localparam int NCP   = 8;
  localparam int TOTAL = FOLD * NS + NS - 1;

  logic clk = 0, rst_n = 0, start = 0, sampValid = 0;
  logic signed [7:0] sampRe = 0, sampIm = 0;
  logic [5:0] symStart;
  logic symDone;

  int sRe [TOTAL];
  int sIm [TOTAL];
  int compared = 0, mismatched = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  cp_fold_sync #(.FOLD(FOLD)) i_cp_fold_sync (
    .clk(clk), .rst_n(rst_n), .start(start), .sampValid(sampValid),
    .sampRe(sampRe), .sampIm(sampIm), .symStart(symStart), .symDone(symDone)
  );

  always #5 clk = ~clk;

  function automatic int rnd8();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return int'($signed(lfsr[7:0]));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R4 R5 R6: folded correlation and earliest-maximum pick
  function automatic int modelPeak();
    int best = 0, bestMag = -1;
    for (int p = 0; p < NS; p++) begin
      longint fr = 0, fi = 0, mag;
      for (int k = 0; k < FOLD; k++)
        for (int i = 0; i < NCP; i++) begin
          int m = p + NS * k + i;
          fr += sRe[m] * sRe[m+NFFT] + sIm[m] * sIm[m+NFFT];
          fi += sIm[m] * sRe[m+NFFT] - sRe[m] * sIm[m+NFFT];
        end
      mag = (fr < 0 ? -fr : fr) + (fi < 0 ? -fi : fi);
      if (mag > bestMag) begin bestMag = int'(mag); best = p; end
    end
    return best;
  endfunction

  task automatic runAcq(input string tag, input bit bubbles);
    int doneBad = 0, exp;
    logic [5:0] held;
    @(negedge clk);
    start = 1; sampValid = 1; sampRe = 8'sd77; sampIm = -8'sd55;  // R2: ignored
    @(negedge clk);
    start = 0;
    for (int idx = 0; idx < TOTAL; idx++) begin
      if (bubbles && (idx % 3 == 1)) begin
        sampValid = 0; sampRe = 8'(rnd8()); sampIm = 8'(rnd8());  // R3 garbage
        @(negedge clk);
        if (symDone) doneBad++;
      end
      sampValid = 1; sampRe = 8'(sRe[idx]); sampIm = 8'(sIm[idx]);
      @(negedge clk);
      if (symDone != (idx == TOTAL - 1)) doneBad++;
    end
    sampValid = 0;
    exp = modelPeak();
    check(doneBad == 0, {"R7 done timing ", tag}, doneBad, 0);
    check(symStart == 6'(exp), {"R4 R5 R6 peak ", tag}, int'(symStart), exp);
    check(symStart < 6'(NS), {"R9 range ", tag}, int'(symStart), NS - 1);
    held = symStart;
    doneBad = 0;
    for (int j = 0; j < 45; j++) begin
      sampValid = 1; sampRe = 8'(rnd8()); sampIm = 8'(rnd8());
      @(negedge clk);
      if (symDone || symStart != held) doneBad++;
    end
    sampValid = 0;
    check(doneBad == 0, {"R8 hold after done ", tag}, doneBad, 0);
  endtask

  task automatic fillCp(input int d);
    for (int t = 0; t < TOTAL; t++) begin sRe[t] = rnd8() / 2; sIm[t] = rnd8() / 2; end
    for (int t = 0; t < TOTAL; t++) begin
      int q = (t - d + 4 * NS) % NS;
      if (q < NCP && t + NFFT < TOTAL) begin sRe[t] = sRe[t+NFFT]; sIm[t] = sIm[t+NFFT]; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL R7 watchdog expired actual=hang expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(symDone == 0, "R1 done at reset", int'(symDone), 0);
    check(symStart == 0, "R1 start at reset", int'(symStart), 0);
    rst_n = 1;
    @(negedge clk);

    // R6 tie: all-zero stream
    for (int t = 0; t < TOTAL; t++) begin sRe[t] = 0; sIm[t] = 0; end
    runAcq("zero", 0);
    // R6 tie: constant stream gives equal metric everywhere
    for (int t = 0; t < TOTAL; t++) begin sRe[t] = 5; sIm[t] = -3; end
    runAcq("const", 0);
    // full-scale extremes
    for (int t = 0; t < TOTAL; t++) begin
      sRe[t] = (t % 3 == 0) ? -128 : 127;
      sIm[t] = (t % 5 == 0) ? 127 : -128;
    end
    runAcq("fullscale", 0);
    // sweep all prefix offsets; odd offsets with R3 bubbles
    for (int d = 0; d < NS; d++) begin
      fillCp(d);
      runAcq($sformatf("offset %0d", d), d % 2 == 1);
    end
    // R2 restart mid-run: abandoned history must not leak
    @(negedge clk);
    start = 1; sampValid = 0;
    @(negedge clk);
    start = 0;
    for (int j = 0; j < 70; j++) begin
      sampValid = 1; sampRe = 8'sd100; sampIm = 8'sd100;
      @(negedge clk);
    end
    sampValid = 0;
    fillCp(17);
    runAcq("R2 restart", 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule